// File: doc/BRIEF.md
# Programmable Output Rounding Formatter

This block sits at the output of a filter datapath. It takes a wide signed accumulator word and turns it into a 16-bit registered result. The accumulator carries `FRAC_W` guard bits below the output grid, so output bit k lines up with accumulator bit k+`FRAC_W`.

A 3-bit code picks where the effective least significant bit of the result lies. The block then does four things in order:
- It adds a half-LSB just below that position.
- It clears every bit under it.
- It saturates on overflow.
- It formats the result as two's complement, inverted offset binary or plain unsigned binary.

An active-low output enable blanks the port and raises a high-impedance flag at once, with no clock edge needed. The register behind the port keeps updating while the port is blanked.

Top module: `round_fmt`

## Requirements
- R1: The formatted result appears on `word_o` one rising clock edge after the inputs are applied. While `rst_n` is low the held result is 0.
- R2: Rounding code r (0..7) places the effective LSB at output bit 2r, which is accumulator bit `FRAC_W`+2r. Before truncation, 1 is added at accumulator bit `FRAC_W`+2r-1.
- R3: In two's complement or unsigned format, output bits below bit 2r are 0.
- R4: With `uns_i`=0 and `twos_i`=1, the output is the rounded value in 16-bit two's complement.
- R5: With `uns_i`=0 and `twos_i`=0, output bits 14..0 are the inverse of the two's complement result and bit 15 is unchanged. For example, 0x0124 becomes 0x7EDB.
- R6: With `uns_i`=1, the accumulator is read as unsigned and the output is plain binary. `twos_i` has no effect in this mode.
- R7: In signed modes, a rounded value above 32767 saturates to 0x7FFF with bits below 2r cleared. For example, r=1 gives 0x7FFC.
- R8: In unsigned mode, a rounded value above 65535 saturates to 0xFFFF with bits below 2r cleared. For example, r=7 gives 0xC000.
- R9: While `oe_n_i` is high, `word_o` reads 0 and `hiz_o` reads 1 without waiting for a clock edge. The held result still updates on each edge and shows once `oe_n_i` falls.
- R10: The half-LSB is added toward positive infinity for negative values too. Accumulator 0xFFFF8 (-0.5 LSB) gives 0, and 0xFFFF7 gives 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_i | input | ACC_W (20) | Accumulator word; signed unless `uns_i` is high |
| rnd_sel_i | input | 3 | Rounding code r; the LSB sits at output bit 2r |
| twos_i | input | 1 | 1: two's complement, 0: inverted offset binary (signed mode only) |
| uns_i | input | 1 | 1: unsigned input and output |
| oe_n_i | input | 1 | Output enable, active low, asynchronous |
| word_o | output | 16 | Registered result, blanked to 0 while disabled |
| hiz_o | output | 1 | High when the port is in the high-impedance state |

## Verification
The case that needs the most care is a cycle where rounding and saturation coincide. The half-LSB addition carries the value past the top of the range, so the clamp has to land on the coarse grid of the chosen code rather than on 0x7FFF or 0xFFFF. This is provoked with accumulators just below full scale at several codes, such as 0x7FFE0 with r=1 and 0xFF000 unsigned with r=7. The result is judged against a bench model that rounds with wide integer arithmetic and clamps to the grid maximum. A second collision, clamping followed by offset inversion in the same cycle, is covered by random sweeps over every code and format.

// File: rtl/round_fmt.sv
module round_fmt #(
  parameter int OUT_W    = 16,
  parameter int FRAC_W   = 4,
  parameter int SEL_W    = 3,
  parameter int RND_STEP = 2,
  parameter int ACC_W    = OUT_W + FRAC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] acc_i,
  input  logic [SEL_W-1:0] rnd_sel_i,
  input  logic             twos_i,
  input  logic             uns_i,
  input  logic             oe_n_i,
  output logic [OUT_W-1:0] word_o,
  output logic             hiz_o
);
  localparam int PW = $clog2(ACC_W + 1);
  localparam logic [ACC_W:0] ONE = {{ACC_W{1'b0}}, 1'b1};
  localparam logic [OUT_W-1:0] LOW_ONES = {1'b0, {(OUT_W-1){1'b1}}};

  logic [PW-1:0]    lsb_pos;
  logic [ACC_W:0]   ext, half;
  logic [OUT_W-1:0] gmask, maxv, res, fmt, q_r;
  logic [OUT_W:0]   cl;
  logic             ovf, vld;

  assign lsb_pos = PW'(FRAC_W) + PW'(RND_STEP) * PW'(rnd_sel_i);
  assign ext     = uns_i ? {1'b0, acc_i} : {acc_i[ACC_W-1], acc_i};
  assign half    = ONE << (lsb_pos - PW'(1));
  assign gmask   = ~((OUT_W'(1) << (PW'(RND_STEP) * PW'(rnd_sel_i))) - OUT_W'(1));
  assign cl      = (OUT_W+1)'((ext + half) >> FRAC_W) & {1'b1, gmask};

  assign ovf  = uns_i ? cl[OUT_W] : (cl[OUT_W] ^ cl[OUT_W-1]);
  assign maxv = (uns_i ? {OUT_W{1'b1}} : LOW_ONES) & gmask;
  assign res  = ovf ? maxv : cl[OUT_W-1:0];
  assign fmt  = (uns_i || twos_i) ? res : (res ^ LOW_ONES);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_r <= '0;
      vld <= 1'b0;
    end else begin
      q_r <= fmt;
      vld <= 1'b1;
    end
  end

  assign word_o = oe_n_i ? '0 : q_r;
  assign hiz_o  = oe_n_i;

  // R3: nothing survives below the chosen LSB
  a_r3_low_clear: assert property (@(posedge clk) disable iff (!rst_n)
    vld && ($past(uns_i) || $past(twos_i)) |->
      (q_r & ((OUT_W'(1) << (RND_STEP * $past(rnd_sel_i))) - OUT_W'(1))) == '0);

  // R5: inverted offset binary turns the cleared bits into ones
  a_r5_low_ones: assert property (@(posedge clk) disable iff (!rst_n)
    vld && !$past(uns_i) && !$past(twos_i) |->
      (~q_r & ((OUT_W'(1) << (RND_STEP * $past(rnd_sel_i))) - OUT_W'(1))) == '0);

  // R7: a non-negative signed input never wraps to a negative output
  a_r7_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    vld && !$past(uns_i) && $past(twos_i) && !$past(acc_i[ACC_W-1]) |->
      !q_r[OUT_W-1]);

  // R8: an unsigned input in the upper half stays in the upper half
  a_r8_upper_half: assert property (@(posedge clk) disable iff (!rst_n)
    vld && $past(uns_i) && $past(acc_i[ACC_W-1]) |-> q_r[OUT_W-1]);

  // R9: a disabled port shows nothing
  a_r9_blank: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n_i |-> (word_o == '0) && hiz_o);
endmodule

// File: tb/round_fmt_tb_top.sv
module round_fmt_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] acc = '0;
  logic [2:0]  rnd = '0;
  logic        twos = 1'b1, uns = 1'b0, oe_n = 1'b0;
  logic [15:0] word;
  logic        hiz;
  int checks = 0, errors = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  round_fmt dut_i (.clk(clk), .rst_n(rst_n), .acc_i(acc), .rnd_sel_i(rnd),
                   .twos_i(twos), .uns_i(uns), .oe_n_i(oe_n),
                   .word_o(word), .hiz_o(hiz));

  function automatic logic [15:0] model(logic [19:0] a, int r, logic t, logic u);
    longint v, rv, mx;
    int lsb;
    lsb = 4 + 2 * r;
    v   = u ? longint'({44'd0, a}) : longint'($signed(a));
    rv  = ((v + (longint'(1) <<< (lsb - 1))) >>> lsb) <<< (2 * r);
    mx  = ((u ? 65535 : 32767) >> (2 * r)) << (2 * r);
    if (rv > mx) rv = mx;
    model = 16'(rv);
    if (!u && !t) model = model ^ 16'h7FFF;
  endfunction

  task automatic check(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic drive(string tag, logic [19:0] a, int r, logic t, logic u);
    @(negedge clk);
    acc = a; rnd = 3'(r); twos = t; uns = u;
    exp_q.push_back(model(a, r, t, u));
    tag_q.push_back(tag);
  endtask

  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) check(tag_q.pop_front(), word, exp_q.pop_front());
  end

  task automatic drain();
    repeat (3) @(negedge clk);
  endtask

  initial begin
    #1000000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset", word, 16'h0000);
    rst_n = 1'b1;
    drive("R1 R4 round up", 20'h01238, 0, 1, 0);
    drive("R4 round down", 20'h01237, 0, 1, 0);
    drive("R2 code 2", 20'h01238, 2, 1, 0);
    drive("R2 code 7", 20'h3A5C3, 7, 1, 0);
    drive("R3 code 3", 20'h12345, 3, 1, 0);
    drive("R5 offset", 20'h01238, 0, 0, 0);
    drive("R5 offset neg", 20'hF0010, 1, 0, 0);
    drive("R6 unsigned", 20'h80000, 0, 0, 1);
    drive("R6 unsigned twos ignored", 20'h80000, 0, 1, 1);
    drive("R7 sat r0", 20'h7FFF8, 0, 1, 0);
    drive("R7 sat r1", 20'h7FFE0, 1, 1, 0);
    drive("R7 sat offset", 20'h7FFF8, 0, 0, 0);
    drive("R8 usat r0", 20'hFFFF8, 0, 1, 1);
    drive("R8 usat r7", 20'hFF000, 7, 1, 1);
    drive("R10 neg half", 20'hFFFF8, 0, 1, 0);
    drive("R10 neg below half", 20'hFFFF7, 0, 1, 0);
    drive("R10 most negative", 20'h80000, 4, 1, 0);
    for (int i = 0; i < 400; i++)
      drive("R2 R3 R4 R5 R6 sweep", 20'($urandom()), i % 8, 1'((i / 8) % 2), 1'((i / 16) % 2));
    drain();
    // R9: blank asynchronously, register still updates underneath
    oe_n = 1'b1;
    #1;
    check("R9 word blank", word, 16'h0000);
    check("R9 hiz flag", {15'd0, hiz}, 16'h0001);
    acc = 20'h01238; rnd = 3'd0; twos = 1'b1; uns = 1'b0;
    @(negedge clk);
    check("R9 still blank", word, 16'h0000);
    oe_n = 1'b0;
    #1;
    check("R9 updated under blank", word, 16'h0124);
    check("R9 hiz low", {15'd0, hiz}, 16'h0000);
    drain();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule